// File: doc/BRIEF.md
# Command Ring Control Register

This block is the control and status register for a host controller's command ring. Software reaches it over a plain 32-bit register bus as two words: a low word and a high word. Together they hold a pending 64-byte aligned ring pointer. The low word also holds the ring cycle state, the stop and abort request bits, and a read-only running flag.

The block watches the controller's run/stop input and the doorbell writes. A doorbell that carries the command reason code, while run/stop is 1 and the ring is idle, starts the ring. At that point the block emits a one-cycle fetch-start strobe with a 64-bit start address. The address is the software pointer if software wrote the pointer while the ring was stopped. Otherwise it is the internal dequeue pointer.

The downstream fetch engine reports its progress back through a plain update port, and that port refreshes the internal dequeue pointer. Command fetching itself is outside this block, as are event generation and memory traffic.

Top module: `cmd_ring_ctl`

## Requirements
- R1: After reset the running flag is 0, the cycle state is 0, fetch_start is 0, and both register words read as 0.
- R2: Low-word layout at offset LO_OFS (default 8'h98): bit 0 is the cycle state (read/write), bit 3 is the running flag (read-only). Bits 1, 2, 4, 5 and 31:6 always read 0. The high word at HI_OFS (default 8'h9C) always reads 0.
- R3: While the running flag is 1, writes to either word leave the stored pointer and the cycle state unchanged.
- R4: A doorbell (db_wr=1) with db_reason equal to CMD_REASON (default 0), arriving while run_stop=1 and the ring is idle, sets the running flag at the next clock edge. At that same edge fetch_start is asserted for exactly one cycle.
- R5: A doorbell with any other reason code, or a doorbell that arrives while run_stop=0, changes neither the running flag nor fetch_start.
- R6: A write to the low word with bit 1 (stop) or bit 2 (abort) set clears the running flag at the next clock edge.
- R7: When run_stop is 0, the running flag is 0 from the next clock edge onward.
- R8: On a start, fetch_addr is the software pointer if either word was written while the ring was stopped since the previous start. Otherwise fetch_addr is the internal dequeue pointer.
- R9: The internal dequeue pointer is loaded with fetch_addr on each start, and with deq_upd_ptr whenever deq_upd_valid=1 and no start occurs. Address bits 5:0 are always forced to 0.
- R10: A doorbell that arrives while the ring is already running produces no fetch_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| run_stop | input | 1 | Controller run/stop bit |
| db_wr | input | 1 | Doorbell write strobe |
| db_reason | input | REASON_W | Doorbell reason code |
| deq_upd_valid | input | 1 | Fetch engine reports a new dequeue pointer |
| deq_upd_ptr | input | 64 | Reported dequeue pointer |
| ring_running | output | 1 | Command ring running flag |
| ring_cycle | output | 1 | Ring cycle state |
| fetch_start | output | 1 | One-cycle start strobe |
| fetch_addr | output | 64 | First fetch address, valid with fetch_start |

## Verification
The checker tests several properties on every cycle: the running flag rises only after a qualifying doorbell, fetch_start is a lone pulse that comes with a rising running flag and an aligned address, and stop, abort and a low run/stop each drop the flag one edge later. It also checks that the cycle state holds steady across writes made while the ring is running. Only the bench scenarios can show which pointer a start selects. That covers software-written versus internally tracked, a pointer write discarded while running and seen again only at a later start, and the read-back values of each word.

// File: rtl/crcr_pkg.sv
package crcr_pkg;
  // low-word bit positions; software decodes these
  localparam int unsigned BIT_CYC   = 0;
  localparam int unsigned BIT_STOP  = 1;
  localparam int unsigned BIT_ABORT = 2;
  localparam int unsigned BIT_RUN   = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } word_sel_e;

  typedef enum logic {
    RING_IDLE   = 1'b0,
    RING_ACTIVE = 1'b1
  } ring_state_e;
endpackage

// File: rtl/crcr_regfile.sv
module crcr_regfile
  import crcr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PTR_W      = 64,
  parameter int unsigned ALIGN_BITS = 6,
  parameter logic [ADDR_W-1:0] LO_OFS = 8'h98,
  parameter logic [ADDR_W-1:0] HI_OFS = 8'h9C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              running,
  input  logic              ring_start,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [PTR_W-1:0]  sw_ptr,
  output logic              sw_written,
  output logic              cycle_q,
  output logic              stop_req
);
  localparam int unsigned HI_W = PTR_W - DATA_W;

  word_sel_e              sel;
  logic                   wr_ok;
  logic [DATA_W-1:ALIGN_BITS] ptr_lo_q;
  logic [HI_W-1:0]        ptr_hi_q;

  always_comb begin
    if (bus_addr == LO_OFS)      sel = SEL_LO;
    else if (bus_addr == HI_OFS) sel = SEL_HI;
    else                         sel = SEL_NONE;
  end

  // pointer and cycle writes only land while the ring is stopped
  assign wr_ok    = bus_wr && !running && (sel != SEL_NONE);
  assign stop_req = bus_wr && (sel == SEL_LO) &&
                    (bus_wdata[BIT_STOP] || bus_wdata[BIT_ABORT]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_lo_q   <= '0;
      ptr_hi_q   <= '0;
      cycle_q    <= 1'b0;
      sw_written <= 1'b0;
    end else begin
      if (wr_ok && sel == SEL_LO) begin
        ptr_lo_q <= bus_wdata[DATA_W-1:ALIGN_BITS];
        cycle_q  <= bus_wdata[BIT_CYC];
      end
      if (wr_ok && sel == SEL_HI) ptr_hi_q <= bus_wdata[HI_W-1:0];
      if (ring_start)  sw_written <= 1'b0;
      else if (wr_ok)  sw_written <= 1'b1;
    end
  end

  assign sw_ptr = {ptr_hi_q, ptr_lo_q, {ALIGN_BITS{1'b0}}};

  // pointer field reads zero; only cycle and running are visible
  always_comb begin
    bus_rdata = '0;
    if (sel == SEL_LO) begin
      bus_rdata[BIT_CYC] = cycle_q;
      bus_rdata[BIT_RUN] = running;
    end
  end
endmodule

// File: rtl/crcr_run_ctl.sv
module crcr_run_ctl
  import crcr_pkg::*;
#(
  parameter int unsigned REASON_W = 8,
  parameter logic [REASON_W-1:0] CMD_REASON = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_stop,
  input  logic                db_wr,
  input  logic [REASON_W-1:0] db_reason,
  input  logic                stop_req,
  output logic                running,
  output logic                ring_start
);
  ring_state_e state_q, state_d;
  logic        cmd_db;

  assign cmd_db     = db_wr && (db_reason == CMD_REASON) && run_stop;
  assign ring_start = (state_q == RING_IDLE) && cmd_db && !stop_req;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RING_IDLE:   if (ring_start) state_d = RING_ACTIVE;
      RING_ACTIVE: if (stop_req || !run_stop) state_d = RING_IDLE;
      default:     state_d = RING_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= RING_IDLE;
    else        state_q <= state_d;
  end

  assign running = (state_q == RING_ACTIVE);
endmodule

// File: rtl/crcr_fetch_sel.sv
module crcr_fetch_sel #(
  parameter int unsigned PTR_W      = 64,
  parameter int unsigned ALIGN_BITS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_start,
  input  logic             sw_written,
  input  logic [PTR_W-1:0] sw_ptr,
  input  logic             deq_upd_valid,
  input  logic [PTR_W-1:0] deq_upd_ptr,
  output logic             fetch_start,
  output logic [PTR_W-1:0] fetch_addr
);
  logic [PTR_W-1:0] deq_q;
  logic [PTR_W-1:0] pick;

  always_comb begin
    pick = sw_written ? sw_ptr : deq_q;
    pick[ALIGN_BITS-1:0] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deq_q       <= '0;
      fetch_start <= 1'b0;
      fetch_addr  <= '0;
    end else begin
      fetch_start <= ring_start;
      if (ring_start) begin
        fetch_addr <= pick;
        deq_q      <= pick;
      end else if (deq_upd_valid) begin
        deq_q <= {deq_upd_ptr[PTR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/cmd_ring_ctl.sv
module cmd_ring_ctl #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned REASON_W   = 8,
  parameter int unsigned ALIGN_BITS = 6,
  parameter logic [ADDR_W-1:0]   LO_OFS     = 8'h98,
  parameter logic [ADDR_W-1:0]   HI_OFS     = 8'h9C,
  parameter logic [REASON_W-1:0] CMD_REASON = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                run_stop,
  input  logic                db_wr,
  input  logic [REASON_W-1:0] db_reason,
  input  logic                deq_upd_valid,
  input  logic [63:0]         deq_upd_ptr,
  output logic                ring_running,
  output logic                ring_cycle,
  output logic                fetch_start,
  output logic [63:0]         fetch_addr
);
  localparam int unsigned DATA_W = 32;
  localparam int unsigned PTR_W  = 2 * DATA_W;

  logic [PTR_W-1:0] sw_ptr;
  logic             sw_written, stop_req, ring_start;

  crcr_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W),
    .ALIGN_BITS(ALIGN_BITS), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .running(ring_running), .ring_start(ring_start),
    .bus_rdata(bus_rdata), .sw_ptr(sw_ptr), .sw_written(sw_written),
    .cycle_q(ring_cycle), .stop_req(stop_req)
  );

  crcr_run_ctl #(.REASON_W(REASON_W), .CMD_REASON(CMD_REASON)) u_run (
    .clk(clk), .rst_n(rst_n), .run_stop(run_stop), .db_wr(db_wr),
    .db_reason(db_reason), .stop_req(stop_req),
    .running(ring_running), .ring_start(ring_start)
  );

  crcr_fetch_sel #(.PTR_W(PTR_W), .ALIGN_BITS(ALIGN_BITS)) u_fetch (
    .clk(clk), .rst_n(rst_n), .ring_start(ring_start),
    .sw_written(sw_written), .sw_ptr(sw_ptr),
    .deq_upd_valid(deq_upd_valid), .deq_upd_ptr(deq_upd_ptr),
    .fetch_start(fetch_start), .fetch_addr(fetch_addr)
  );
endmodule

// File: rtl/crcr_checker.sv
module crcr_checker #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned REASON_W = 8,
  parameter logic [ADDR_W-1:0]   LO_OFS     = 8'h98,
  parameter logic [REASON_W-1:0] CMD_REASON = '0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_wdata,
  input logic                run_stop,
  input logic                db_wr,
  input logic [REASON_W-1:0] db_reason,
  input logic                ring_running,
  input logic                ring_cycle,
  input logic                fetch_start,
  input logic [63:0]         fetch_addr
);
  logic lo_wr, stop_wr, cmd_db;
  assign lo_wr   = bus_wr && (bus_addr == LO_OFS);
  assign stop_wr = lo_wr && (bus_wdata[1] || bus_wdata[2]);
  assign cmd_db  = db_wr && (db_reason == CMD_REASON) && run_stop;

  assert_rise_needs_doorbell_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ring_running ##1 ring_running) |-> $past(cmd_db));
  assert_start_with_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |-> ring_running);
  assert_start_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |=> !fetch_start);
  assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> !ring_running);
  assert_runstop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_stop |=> !ring_running);
  assert_cycle_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_running && lo_wr) |=> $stable(ring_cycle));
  assert_addr_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |-> (fetch_addr[5:0] == 6'd0));
endmodule

bind cmd_ring_ctl crcr_checker #(
  .ADDR_W(ADDR_W), .REASON_W(REASON_W), .LO_OFS(LO_OFS), .CMD_REASON(CMD_REASON)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .run_stop(run_stop), .db_wr(db_wr),
  .db_reason(db_reason), .ring_running(ring_running), .ring_cycle(ring_cycle),
  .fetch_start(fetch_start), .fetch_addr(fetch_addr)
);

// File: tb/cmd_ring_ctl_test.sv
module cmd_ring_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h98;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        run_stop = 1'b0;
  logic        db_wr = 1'b0;
  logic [7:0]  db_reason = '0;
  logic        deq_upd_valid = 1'b0;
  logic [63:0] deq_upd_ptr = '0;
  logic        ring_running, ring_cycle, fetch_start;
  logic [63:0] fetch_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmd_ring_ctl uut (.*);

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic ring_db(logic [7:0] reason);
    db_wr = 1'b1; db_reason = reason;
    tick();
    db_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 running", ring_running, 0);
    chk("R1 cycle", ring_cycle, 0);
    chk("R1 fetch_start", fetch_start, 0);
    rd(8'h98, d); chk("R1 lo", d, 0);
    rd(8'h9C, d); chk("R1 hi", d, 0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wr(8'h98, 32'hFFFF_FFF9);   // cycle=1, no stop/abort
    rd(8'h98, d); chk("R2 lo readback", d, 32'h1);
    wr(8'h9C, 32'hDEAD_BEEF);
    rd(8'h9C, d); chk("R2 hi readback", d, 0);
  endtask

  task automatic t_ignored_db();
    run_stop = 1'b0;
    ring_db(8'h00);
    chk("R5 rs=0 running", ring_running, 0);
    chk("R5 rs=0 fetch", fetch_start, 0);
    run_stop = 1'b1;
    ring_db(8'h05);
    chk("R5 reason running", ring_running, 0);
    chk("R5 reason fetch", fetch_start, 0);
  endtask

  task automatic t_start_sw();
    logic [31:0] d;
    wr(8'h98, 32'h1234_5681);
    wr(8'h9C, 32'h0000_00AB);
    ring_db(8'h00);
    chk("R4 running", ring_running, 1);
    chk("R4 fetch_start", fetch_start, 1);
    chk("R8 sw addr", fetch_addr, 64'h0000_00AB_1234_5680);
    rd(8'h98, d); chk("R2 lo running", d, 32'h9);
    tick();
    chk("R4 single pulse", fetch_start, 0);
    ring_db(8'h00);
    chk("R10 no restart", fetch_start, 0);
  endtask

  task automatic t_ignored_writes();
    wr(8'h98, 32'h0000_0FC0);   // cycle=0, no stop
    chk("R3 cycle kept", ring_cycle, 1);
    wr(8'h9C, 32'h0000_0077);
    deq_upd_valid = 1'b1; deq_upd_ptr = 64'h0000_0001_0000_0047;
    tick();
    deq_upd_valid = 1'b0;
    wr(8'h98, 32'h0000_0002);   // stop
    chk("R6 stop", ring_running, 0);
    chk("R3 cycle after stop", ring_cycle, 1);
    ring_db(8'h00);
    chk("R3 R9 deq addr", fetch_addr, 64'h0000_0001_0000_0040);
    chk("R4 restart", fetch_start, 1);
  endtask

  task automatic t_abort_rs();
    wr(8'h98, 32'h0000_0004);   // abort
    chk("R6 abort", ring_running, 0);
    ring_db(8'h00);
    chk("R9 resume same", fetch_addr, 64'h0000_0001_0000_0040);
    run_stop = 1'b0;
    tick();
    chk("R7 run_stop", ring_running, 0);
    run_stop = 1'b1;
    wr(8'h98, 32'h0000_0200);
    ring_db(8'h00);
    chk("R8 new sw addr", fetch_addr, 64'h0000_00AB_0000_0200);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_layout();
    t_ignored_db();
    t_start_sw();
    t_ignored_writes();
    t_abort_rs();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule